// File: doc/BRIEF.md
# Next Fetch Address Selector

This block works out where instruction fetch goes next, one fetched instruction at a time. It holds three pieces of fetch state: the current fetch address, the address that follows it, and an index into the micro-operation sequence of the current macro-instruction. When an instruction is presented with its valid strobe, the block uses that instruction's kind and the branch predictor's verdict (taken flag and target) to step these three values. It also tags the instruction with the prediction it was fetched under, and counts control instructions and predicted-taken control instructions.

A build-time switch picks between two control-flow models. In the first, a taken branch changes the very next fetch address. In the second, the instruction after a branch always executes (a delay slot), so the predicted target only enters the following-address register. A redirect input, used when the pipeline is flushed, loads all three state values directly and wins over any instruction presented in the same cycle. The branch predictor itself lives outside; only its result arrives here.

Top module: `npc_selector`

## Requirements
- R1: Synchronous active-high reset sets the current address to BOOT_PC, the following address to BOOT_PC + INST_BYTES (default 4), the micro-op index to 0, the taken tag to 0 and both counters to 0.
- R2: A valid non-control instruction that is a micro-op but not the last one of its sequence adds 1 to the micro-op index (wrapping at its width) and leaves both addresses unchanged.
- R3: Any other valid non-control instruction moves the following address into the current address, adds INST_BYTES to the following address and clears the micro-op index.
- R4: A valid non-control instruction sets the taken tag to 0, whatever the predictor's taken input says.
- R5: A valid control instruction clears the micro-op index, and the taken tag takes the predictor's taken input.
- R6: With DELAY_SLOT = 1, a valid control instruction moves the old following address into the current address; the new following address is the predicted target when taken, else the old following address plus INST_BYTES.
- R7: With DELAY_SLOT = 0, a valid control instruction sets the current address to the predicted target when taken, else to the old current address plus INST_BYTES; the following address is the new current address plus INST_BYTES.
- R8: Each valid control instruction adds 1 to the branch counter, and each one that is predicted taken also adds 1 to the taken counter; counters wrap at CNT_W bits.
- R9: When redirect is high, the three state values load the redirect address, following address and micro-op index in that cycle, the taken tag is cleared and neither counter changes, even if a valid instruction is present.
- R10: With neither valid nor redirect high, all outputs hold their values, whatever the other inputs carry.
- R11: Every result appears on the outputs one clock edge after the inputs that cause it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | An instruction is presented this cycle |
| is_ctrl_i | input | 1 | Instruction is a control-flow instruction |
| is_uop_i | input | 1 | Instruction is a micro-op of a longer sequence |
| is_last_uop_i | input | 1 | Instruction is the final micro-op of its sequence |
| bp_taken_i | input | 1 | Predictor says taken |
| bp_target_i | input | 32 | Predicted target address |
| redir_i | input | 1 | Flush redirect, overrides the instruction update |
| redir_pc_i | input | 32 | Redirect current address |
| redir_npc_i | input | 32 | Redirect following address |
| redir_upc_i | input | 8 | Redirect micro-op index |
| pc_o | output | 32 | Current fetch address |
| npc_o | output | 32 | Following fetch address |
| upc_o | output | 8 | Micro-op index |
| taken_tag_o | output | 1 | Prediction tag of the last accepted instruction |
| br_count_o | output | CNT_W | Control instructions seen |
| taken_count_o | output | CNT_W | Control instructions predicted taken |

## Verification
Two copies of the block, one per control-flow model, receive the same stream so the delay-slot and direct-branch results are told apart on identical inputs. The stream mixes plain sequential instructions, runs of mid-sequence micro-ops ended by a last micro-op, control instructions predicted not taken and taken to different targets, and a non-control instruction that carries a stray taken flag, which separates the tag rule from the predictor input. Redirects arrive both alone and together with a valid taken branch, showing that the flush wins and leaves the counters alone, and idle cycles with garbage on the instruction inputs show that nothing moves without the strobe.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int ADDR_W = 32;
    localparam int UPC_W  = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [UPC_W-1:0]  upc_t;

    // architectural fetch pointer
    typedef struct packed {
        addr_t pc;
        addr_t npc;
        upc_t  upc;
    } fetch_ptr_t;

    // description of the fetched instruction plus predictor verdict
    typedef struct packed {
        logic  is_ctrl;
        logic  is_uop;
        logic  is_last_uop;
        logic  bp_taken;
        addr_t bp_target;
    } inst_info_t;

    typedef enum logic [1:0] {
        STEP_UOP    = 2'd0,
        STEP_SEQ    = 2'd1,
        STEP_BRANCH = 2'd2
    } step_kind_t;

    function automatic step_kind_t classify(input inst_info_t inst);
        if (inst.is_ctrl)
            return STEP_BRANCH;
        else if (inst.is_uop && !inst.is_last_uop)
            return STEP_UOP;
        else
            return STEP_SEQ;
    endfunction

endpackage

// File: rtl/npc_next_calc.sv
module npc_next_calc
    import npc_pkg::*;
#(
    parameter int INST_BYTES = 4,
    parameter bit DELAY_SLOT = 1'b0
) (
    input  fetch_ptr_t cur,
    input  inst_info_t inst,
    output fetch_ptr_t nxt,
    output logic       taken,
    output logic       is_branch
);
    localparam addr_t STEP = addr_t'(INST_BYTES);

    step_kind_t kind;
    fetch_ptr_t br_ptr;

    assign kind = classify(inst);

    generate
        if (DELAY_SLOT) begin : g_slot
            always_comb begin
                br_ptr.pc  = cur.npc;
                br_ptr.npc = inst.bp_taken ? inst.bp_target : cur.npc + STEP;
                br_ptr.upc = '0;
            end
        end else begin : g_direct
            addr_t tgt;
            always_comb begin
                tgt        = inst.bp_taken ? inst.bp_target : cur.pc + STEP;
                br_ptr.pc  = tgt;
                br_ptr.npc = tgt + STEP;
                br_ptr.upc = '0;
            end
        end
    endgenerate

    always_comb begin
        nxt       = cur;
        taken     = 1'b0;
        is_branch = 1'b0;
        unique case (kind)
            STEP_UOP: begin
                nxt.upc = cur.upc + upc_t'(1);
            end
            STEP_SEQ: begin
                nxt.pc  = cur.npc;
                nxt.npc = cur.npc + STEP;
                nxt.upc = '0;
            end
            STEP_BRANCH: begin
                nxt       = br_ptr;
                taken     = inst.bp_taken;
                is_branch = 1'b1;
            end
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/npc_branch_stats.sv
module npc_branch_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             br_en,
    input  logic             taken_en,
    output logic [CNT_W-1:0] br_count,
    output logic [CNT_W-1:0] taken_count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            br_count    <= '0;
            taken_count <= '0;
        end else begin
            if (br_en)
                br_count <= br_count + CNT_W'(1);
            if (br_en && taken_en)
                taken_count <= taken_count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/npc_selector.sv
module npc_selector
    import npc_pkg::*;
#(
    parameter int          INST_BYTES = 4,
    parameter bit          DELAY_SLOT = 1'b0,
    parameter int          CNT_W      = 16,
    parameter logic [31:0] BOOT_PC    = 32'h0000_1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic             is_ctrl_i,
    input  logic             is_uop_i,
    input  logic             is_last_uop_i,
    input  logic             bp_taken_i,
    input  logic [31:0]      bp_target_i,
    input  logic             redir_i,
    input  logic [31:0]      redir_pc_i,
    input  logic [31:0]      redir_npc_i,
    input  logic [7:0]       redir_upc_i,
    output logic [31:0]      pc_o,
    output logic [31:0]      npc_o,
    output logic [7:0]       upc_o,
    output logic             taken_tag_o,
    output logic [CNT_W-1:0] br_count_o,
    output logic [CNT_W-1:0] taken_count_o
);
    localparam addr_t BOOT_NPC = addr_t'(BOOT_PC) + addr_t'(INST_BYTES);

    fetch_ptr_t ptr_q, ptr_calc;
    inst_info_t inst;
    logic       calc_taken, calc_branch, accept;
    logic       tag_q;

    assign inst = '{is_ctrl: is_ctrl_i, is_uop: is_uop_i,
                    is_last_uop: is_last_uop_i, bp_taken: bp_taken_i,
                    bp_target: bp_target_i};

    // instruction update only when no redirect is pending
    assign accept = valid_i && !redir_i;

    npc_next_calc #(
        .INST_BYTES (INST_BYTES),
        .DELAY_SLOT (DELAY_SLOT)
    ) u_calc (
        .cur       (ptr_q),
        .inst      (inst),
        .nxt       (ptr_calc),
        .taken     (calc_taken),
        .is_branch (calc_branch)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q.pc  <= addr_t'(BOOT_PC);
            ptr_q.npc <= BOOT_NPC;
            ptr_q.upc <= '0;
            tag_q     <= 1'b0;
        end else if (redir_i) begin
            ptr_q.pc  <= redir_pc_i;
            ptr_q.npc <= redir_npc_i;
            ptr_q.upc <= redir_upc_i;
            tag_q     <= 1'b0;
        end else if (valid_i) begin
            ptr_q <= ptr_calc;
            tag_q <= calc_taken;
        end
    end

    npc_branch_stats #(
        .CNT_W (CNT_W)
    ) u_stats (
        .clk         (clk),
        .rst         (rst),
        .br_en       (accept && calc_branch),
        .taken_en    (calc_taken),
        .br_count    (br_count_o),
        .taken_count (taken_count_o)
    );

    assign pc_o        = ptr_q.pc;
    assign npc_o       = ptr_q.npc;
    assign upc_o       = ptr_q.upc;
    assign taken_tag_o = tag_q;
endmodule

// File: rtl/npc_selector_checker.sv
module npc_selector_checker #(
    parameter int INST_BYTES = 4,
    parameter bit DELAY_SLOT = 1'b0,
    parameter int CNT_W      = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             valid_i,
    input logic             is_ctrl_i,
    input logic             is_uop_i,
    input logic             is_last_uop_i,
    input logic             bp_taken_i,
    input logic [31:0]      bp_target_i,
    input logic             redir_i,
    input logic [31:0]      redir_pc_i,
    input logic [7:0]       redir_upc_i,
    input logic [31:0]      pc_o,
    input logic [31:0]      npc_o,
    input logic [7:0]       upc_o,
    input logic             taken_tag_o,
    input logic [CNT_W-1:0] br_count_o,
    input logic [CNT_W-1:0] taken_count_o
);
    logic go;
    assign go = valid_i && !redir_i;

    assert_uop_step_R2: assert property (@(posedge clk) disable iff (rst)
        go && !is_ctrl_i && is_uop_i && !is_last_uop_i
        |=> $stable(pc_o) && $stable(npc_o) && upc_o == $past(upc_o) + 8'd1);

    assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
        go && !is_ctrl_i && !(is_uop_i && !is_last_uop_i)
        |=> pc_o == $past(npc_o) && npc_o == $past(npc_o) + 32'(INST_BYTES) && upc_o == 8'd0);

    assert_plain_untagged_R4: assert property (@(posedge clk) disable iff (rst)
        go && !is_ctrl_i |=> !taken_tag_o);

    assert_branch_upc_R5: assert property (@(posedge clk) disable iff (rst)
        go && is_ctrl_i |=> upc_o == 8'd0 && taken_tag_o == $past(bp_taken_i));

    generate
        if (DELAY_SLOT) begin : g_slot_chk
            assert_slot_pc_R6: assert property (@(posedge clk) disable iff (rst)
                go && is_ctrl_i |=> pc_o == $past(npc_o));
        end else begin : g_direct_chk
            assert_direct_taken_R7: assert property (@(posedge clk) disable iff (rst)
                go && is_ctrl_i && bp_taken_i
                |=> pc_o == $past(bp_target_i) && npc_o == pc_o + 32'(INST_BYTES));
        end
    endgenerate

    assert_branch_count_R8: assert property (@(posedge clk) disable iff (rst)
        go && is_ctrl_i |=> br_count_o == $past(br_count_o) + CNT_W'(1));

    assert_redirect_R9: assert property (@(posedge clk) disable iff (rst)
        redir_i |=> pc_o == $past(redir_pc_i) && upc_o == $past(redir_upc_i)
                    && $stable(br_count_o) && $stable(taken_count_o) && !taken_tag_o);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !valid_i && !redir_i |=> $stable(pc_o) && $stable(npc_o) && $stable(upc_o)
                                 && $stable(br_count_o) && $stable(taken_tag_o));
endmodule

bind npc_selector npc_selector_checker #(
    .INST_BYTES (INST_BYTES),
    .DELAY_SLOT (DELAY_SLOT),
    .CNT_W      (CNT_W)
) u_checker (
    .clk           (clk),
    .rst           (rst),
    .valid_i       (valid_i),
    .is_ctrl_i     (is_ctrl_i),
    .is_uop_i      (is_uop_i),
    .is_last_uop_i (is_last_uop_i),
    .bp_taken_i    (bp_taken_i),
    .bp_target_i   (bp_target_i),
    .redir_i       (redir_i),
    .redir_pc_i    (redir_pc_i),
    .redir_upc_i   (redir_upc_i),
    .pc_o          (pc_o),
    .npc_o         (npc_o),
    .upc_o         (upc_o),
    .taken_tag_o   (taken_tag_o),
    .br_count_o    (br_count_o),
    .taken_count_o (taken_count_o)
);

// File: tb/npc_selector_test.sv
module npc_selector_test;
    localparam int          CNT_W = 16;
    localparam logic [31:0] BOOT  = 32'h0000_1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk; // 200 MHz

    logic        valid_i = 0, is_ctrl_i = 0, is_uop_i = 0, is_last_uop_i = 0;
    logic        bp_taken_i = 0, redir_i = 0;
    logic [31:0] bp_target_i = 0, redir_pc_i = 0, redir_npc_i = 0;
    logic [7:0]  redir_upc_i = 0;

    logic [31:0] pc0, npc0, pc1, npc1;
    logic [7:0]  upc0, upc1;
    logic        tag0, tag1;
    logic [CNT_W-1:0] br0, tk0, br1, tk1;

    // direct-branch model
    npc_selector #(.INST_BYTES(4), .DELAY_SLOT(1'b0), .CNT_W(CNT_W), .BOOT_PC(BOOT)) uut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .is_ctrl_i(is_ctrl_i), .is_uop_i(is_uop_i),
        .is_last_uop_i(is_last_uop_i), .bp_taken_i(bp_taken_i), .bp_target_i(bp_target_i),
        .redir_i(redir_i), .redir_pc_i(redir_pc_i), .redir_npc_i(redir_npc_i),
        .redir_upc_i(redir_upc_i), .pc_o(pc0), .npc_o(npc0), .upc_o(upc0),
        .taken_tag_o(tag0), .br_count_o(br0), .taken_count_o(tk0));

    // delay-slot model
    npc_selector #(.INST_BYTES(4), .DELAY_SLOT(1'b1), .CNT_W(CNT_W), .BOOT_PC(BOOT)) uut_ds (
        .clk(clk), .rst(rst), .valid_i(valid_i), .is_ctrl_i(is_ctrl_i), .is_uop_i(is_uop_i),
        .is_last_uop_i(is_last_uop_i), .bp_taken_i(bp_taken_i), .bp_target_i(bp_target_i),
        .redir_i(redir_i), .redir_pc_i(redir_pc_i), .redir_npc_i(redir_npc_i),
        .redir_upc_i(redir_upc_i), .pc_o(pc1), .npc_o(npc1), .upc_o(upc1),
        .taken_tag_o(tag1), .br_count_o(br1), .taken_count_o(tk1));

    typedef struct {
        logic [31:0] pc0, npc0, pc1, npc1;
        logic [7:0]  upc0, upc1;
        logic        tag0, tag1;
        logic [CNT_W-1:0] br, tk;
        int          req;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0, fails = 0;
    bit done = 0;

    // reference state
    logic [31:0] m_pc0, m_npc0, m_pc1, m_npc1;
    logic [7:0]  m_upc0, m_upc1;
    logic        m_tag0, m_tag1;
    logic [CNT_W-1:0] m_br, m_tk;

    task automatic chk32(input int req, input string what, input logic [31:0] act, input logic [31:0] e);
        checks++;
        if (act !== e) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, e);
        end
    endtask

    task automatic model_reset();
        m_pc0 = BOOT; m_npc0 = BOOT + 4; m_upc0 = 0; m_tag0 = 0;
        m_pc1 = BOOT; m_npc1 = BOOT + 4; m_upc1 = 0; m_tag1 = 0;
        m_br = 0; m_tk = 0;
    endtask

    // drive one cycle of stimulus and push what the outputs must show after the edge
    task automatic drive(input int req, input logic v, input logic c, input logic u, input logic l,
                         input logic t, input logic [31:0] tgt, input logic r,
                         input logic [31:0] rpc, input logic [31:0] rnpc, input logic [7:0] rupc);
        exp_t e;
        @(negedge clk);
        valid_i = v; is_ctrl_i = c; is_uop_i = u; is_last_uop_i = l;
        bp_taken_i = t; bp_target_i = tgt; redir_i = r;
        redir_pc_i = rpc; redir_npc_i = rnpc; redir_upc_i = rupc;
        if (r) begin
            m_pc0 = rpc; m_npc0 = rnpc; m_upc0 = rupc; m_tag0 = 0;
            m_pc1 = rpc; m_npc1 = rnpc; m_upc1 = rupc; m_tag1 = 0;
        end else if (v) begin
            if (!c && u && !l) begin
                m_upc0 = m_upc0 + 1; m_upc1 = m_upc1 + 1; m_tag0 = 0; m_tag1 = 0;
            end else if (!c) begin
                m_pc0 = m_npc0; m_npc0 = m_npc0 + 4; m_upc0 = 0; m_tag0 = 0;
                m_pc1 = m_npc1; m_npc1 = m_npc1 + 4; m_upc1 = 0; m_tag1 = 0;
            end else begin
                m_pc0 = t ? tgt : m_pc0 + 4; m_npc0 = m_pc0 + 4; m_upc0 = 0; m_tag0 = t;
                m_pc1 = m_npc1; m_npc1 = t ? tgt : m_npc1 + 4; m_upc1 = 0; m_tag1 = t;
                m_br = m_br + 1;
                if (t) m_tk = m_tk + 1;
            end
        end
        e.pc0 = m_pc0; e.npc0 = m_npc0; e.upc0 = m_upc0; e.tag0 = m_tag0;
        e.pc1 = m_pc1; e.npc1 = m_npc1; e.upc1 = m_upc1; e.tag1 = m_tag1;
        e.br = m_br; e.tk = m_tk; e.req = req;
        exp_q.push_back(e);
    endtask

    // monitor: compare one edge after each driven cycle (R11)
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk32(e.req, "pc direct",  pc0,  e.pc0);
            chk32(e.req, "npc direct", npc0, e.npc0);
            chk32(e.req, "upc direct", {24'b0, upc0}, {24'b0, e.upc0});
            chk32(e.req, "tag direct", {31'b0, tag0}, {31'b0, e.tag0});
            chk32(e.req, "pc slot",    pc1,  e.pc1);
            chk32(e.req, "npc slot",   npc1, e.npc1);
            chk32(e.req, "upc slot",   {24'b0, upc1}, {24'b0, e.upc1});
            chk32(e.req, "tag slot",   {31'b0, tag1}, {31'b0, e.tag1});
            chk32(e.req, "branch count", 32'(br0), 32'(e.br));
            chk32(e.req, "taken count",  32'(tk0), 32'(e.tk));
            chk32(e.req, "branch count slot", 32'(br1), 32'(e.br));
            chk32(e.req, "taken count slot",  32'(tk1), 32'(e.tk));
        end
    end

    initial begin
        #200000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset values
        chk32(1, "reset pc",  pc0,  BOOT);
        chk32(1, "reset npc", npc1, BOOT + 4);
        chk32(1, "reset upc", {24'b0, upc0}, 32'd0);
        chk32(1, "reset count", 32'(br0), 32'd0);
        // R3: plain sequential instructions; R4 stray taken flag ignored
        drive(3, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        drive(4, 1, 0, 0, 0, 1, 32'hdead_0000, 0, 0, 0, 0);
        // R2: mid micro-ops, then R3 last micro-op
        drive(2, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        drive(2, 1, 0, 1, 0, 1, 32'h0000_0bad, 0, 0, 0, 0);
        drive(2, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        drive(3, 1, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        // R5 micro-op index cleared by a branch
        drive(2, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        drive(5, 1, 1, 1, 0, 0, 32'h0000_4000, 0, 0, 0, 0);
        // R6 / R7: taken branches
        drive(7, 1, 1, 0, 0, 1, 32'h0000_2000, 0, 0, 0, 0);
        drive(6, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        drive(6, 1, 1, 0, 0, 1, 32'h0000_3000, 0, 0, 0, 0);
        drive(7, 1, 1, 0, 0, 0, 32'h0000_5000, 0, 0, 0, 0);
        // R10: idle with garbage
        drive(10, 0, 1, 1, 0, 1, 32'hffff_fff0, 0, 32'h1111_1111, 0, 0);
        drive(10, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        // R9: redirect with a taken branch present, and redirect alone
        drive(9, 1, 1, 0, 0, 1, 32'h0000_6000, 1, 32'h0000_8000, 32'h0000_8004, 8'd3);
        drive(2, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        drive(9, 0, 0, 0, 0, 0, 0, 1, 32'h0000_9000, 32'h0000_9100, 8'd0);
        drive(8, 1, 1, 0, 0, 1, 32'h0000_a000, 0, 0, 0, 0);
        drive(8, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        drive(10, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        valid_i = 0; redir_i = 0;
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule